// File: doc/BRIEF.md
# CSR Access Privilege Checker

This block judges every control and status register access issued by a RISC-V core that implements the hypervisor extension. For each access it receives the 12-bit register address, the access kind, whether a read-modify-write has a zero source operand, the current privilege level, the virtualization bit and the instruction bits. One cycle later it reports one of three outcomes: the access is allowed, it raises an illegal-instruction exception, or it raises a virtual-instruction exception. With the outcome it gives the matching trap cause code and the trap value.

While the hart runs virtualized, a privilege failure is split by the level the register demands. A register that needs supervisor or hypervisor level gives a virtual-instruction trap, so the hypervisor can emulate it. A register that needs machine level gives an illegal-instruction trap. A VU-mode read of a supervisor register therefore produces the virtual-instruction cause. The trap-virtual-memory control is taken as zero throughout.

Top module: `csr_priv_guard`

## Requirements
- R1: The required level is address bits [9:8]. A privilege failure occurs when the effective privilege is numerically below that level. Effective privilege is `cur_priv` (U=0, S=1, M=3), with virtualized U giving 0 and virtualized S giving 1. `virt_on` has no effect when `cur_priv` is 3.
- R2: A privilege failure while virtualization is in effect, on a register whose required level is 2 or less and which is not a read-only write violation, sets `rsp_virtual` with cause 22.
- R3: A privilege failure with virtualization not in effect, or on a register needing level 3, sets `rsp_illegal` with cause 2.
- R4: A write access to an address whose bits [11:10] are 2'b11 sets `rsp_illegal` with cause 2 at any privilege level, with or without virtualization. This outcome wins over R2.
- R5: `req_op` encodes 0 as read, 1 as write, 2 as read-modify-write set and 3 as read-modify-write clear. Ops 2 and 3 with `req_src_zero` high count as reads. Op 1 always counts as a write.
- R6: An allowed access sets `rsp_ok`, with cause 0 and trap value 0.
- R7: Each cycle with `req_valid` high produces exactly one `rsp_valid` pulse on the next cycle. When `rsp_valid` is low, all flags, the cause and the trap value are 0.
- R8: When a trap is reported, `rsp_tval` carries the `req_insn` of the access that caused it.
- R9: When `rsp_valid` is high, exactly one of `rsp_ok`, `rsp_illegal` and `rsp_virtual` is set. The two exception flags are never high together.
- R10: While reset is active and right after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access to judge this cycle |
| req_addr | input | 12 | CSR address |
| req_op | input | 2 | Access kind (R5 encoding) |
| req_src_zero | input | 1 | Read-modify-write source is zero |
| cur_priv | input | 2 | Current privilege level |
| virt_on | input | 1 | Virtualization bit |
| req_insn | input | INSN_W | Instruction bits of the access |
| rsp_valid | output | 1 | Outcome valid |
| rsp_ok | output | 1 | Access allowed |
| rsp_illegal | output | 1 | Illegal-instruction exception |
| rsp_virtual | output | 1 | Virtual-instruction exception |
| rsp_cause | output | CAUSE_W | Trap cause code (0, 2 or 22) |
| rsp_tval | output | INSN_W | Trap value |

## Verification
The hardest case to reach is a virtualized write to read-only space that also fails the privilege check. Here the read-only rule must override the virtual-instruction outcome. Random addresses seldom combine the right bits [11:10], bits [9:8], privilege and op all at once. The random stimulus therefore draws the two top address fields and the op on their own from small ranges, so every combination appears many times. Directed cases also pin the VU read of a supervisor register, a VS read of a hypervisor-level register and zero-source read-modify-writes to read-only space.

// File: rtl/csrg_pkg.sv
package csrg_pkg;
  localparam int CSR_ADDR_W = 12;
  localparam int PRIV_W     = 2;

  localparam logic [1:0] LVL_U  = 2'd0;
  localparam logic [1:0] LVL_S  = 2'd1;
  localparam logic [1:0] LVL_HS = 2'd2;
  localparam logic [1:0] LVL_M  = 2'd3;

  localparam int CODE_ILLEGAL = 2;
  localparam int CODE_VIRTUAL = 22;

  typedef enum logic [1:0] {
    VERDICT_OK   = 2'd0,
    VERDICT_ILL  = 2'd1,
    VERDICT_VIRT = 2'd2
  } verdict_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } acc_op_e;

  function automatic logic [1:0] needed_level(input logic [CSR_ADDR_W-1:0] a);
    return a[9:8];
  endfunction

  function automatic logic in_ro_space(input logic [CSR_ADDR_W-1:0] a);
    return a[11:10] == 2'b11;
  endfunction

  function automatic logic does_write(input logic [1:0] op, input logic src_zero);
    case (op)
      OP_READ:  return 1'b0;
      OP_WRITE: return 1'b1;
      default:  return !src_zero;
    endcase
  endfunction
endpackage

// File: rtl/csrg_level_map.sv
module csrg_level_map
  import csrg_pkg::*;
(
  input  logic [PRIV_W-1:0] cur_priv,
  input  logic              virt_on,
  output logic [PRIV_W-1:0] eff_priv,
  output logic              virt_eff
);
  always_comb begin
    virt_eff = virt_on && (cur_priv != LVL_M);
    if (virt_eff) eff_priv = (cur_priv == LVL_U) ? LVL_U : LVL_S;
    else          eff_priv = cur_priv;
  end
endmodule

// File: rtl/csrg_judge.sv
module csrg_judge
  import csrg_pkg::*;
(
  input  logic [CSR_ADDR_W-1:0] addr,
  input  logic [1:0]            op,
  input  logic                  src_zero,
  input  logic [PRIV_W-1:0]     eff_priv,
  input  logic                  virt_eff,
  output logic                  priv_fail,
  output logic                  ro_fail,
  output verdict_e              verdict
);
  logic [1:0] need;

  always_comb begin
    need      = needed_level(addr);
    priv_fail = eff_priv < need;
    ro_fail   = in_ro_space(addr) && does_write(op, src_zero);
    verdict   = VERDICT_OK;
    if (priv_fail) begin
      if (virt_eff && (need <= LVL_HS) && !ro_fail) verdict = VERDICT_VIRT;
      else                                         verdict = VERDICT_ILL;
    end else if (ro_fail) begin
      verdict = VERDICT_ILL;
    end
  end
endmodule

// File: rtl/csrg_resp_reg.sv
module csrg_resp_reg
  import csrg_pkg::*;
#(
  parameter int INSN_W  = 32,
  parameter int CAUSE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  verdict_e           in_verdict,
  input  logic [INSN_W-1:0]  in_insn,
  output logic               out_valid,
  output logic               out_ok,
  output logic               out_ill,
  output logic               out_virt,
  output logic [CAUSE_W-1:0] out_cause,
  output logic [INSN_W-1:0]  out_tval
);
  localparam logic [CAUSE_W-1:0] C_ILL  = CAUSE_W'(CODE_ILLEGAL);
  localparam logic [CAUSE_W-1:0] C_VIRT = CAUSE_W'(CODE_VIRTUAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ok    <= 1'b0;
      out_ill   <= 1'b0;
      out_virt  <= 1'b0;
      out_cause <= '0;
      out_tval  <= '0;
    end else begin
      out_valid <= in_valid;
      out_ok    <= in_valid && (in_verdict == VERDICT_OK);
      out_ill   <= in_valid && (in_verdict == VERDICT_ILL);
      out_virt  <= in_valid && (in_verdict == VERDICT_VIRT);
      if (in_valid && in_verdict == VERDICT_ILL)       out_cause <= C_ILL;
      else if (in_valid && in_verdict == VERDICT_VIRT) out_cause <= C_VIRT;
      else                                             out_cause <= '0;
      out_tval <= (in_valid && in_verdict != VERDICT_OK) ? in_insn : '0;
    end
  end
endmodule

// File: rtl/csr_priv_guard.sv
module csr_priv_guard
  import csrg_pkg::*;
#(
  parameter int INSN_W  = 32,
  parameter int CAUSE_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [CSR_ADDR_W-1:0] req_addr,
  input  logic [1:0]            req_op,
  input  logic                  req_src_zero,
  input  logic [PRIV_W-1:0]     cur_priv,
  input  logic                  virt_on,
  input  logic [INSN_W-1:0]     req_insn,
  output logic                  rsp_valid,
  output logic                  rsp_ok,
  output logic                  rsp_illegal,
  output logic                  rsp_virtual,
  output logic [CAUSE_W-1:0]    rsp_cause,
  output logic [INSN_W-1:0]     rsp_tval
);
  logic [PRIV_W-1:0] eff_priv;
  logic              virt_eff;
  logic              priv_fail;
  logic              ro_fail;
  verdict_e          verdict;

  csrg_level_map u_map (
    .cur_priv (cur_priv),
    .virt_on  (virt_on),
    .eff_priv (eff_priv),
    .virt_eff (virt_eff)
  );

  csrg_judge u_judge (
    .addr      (req_addr),
    .op        (req_op),
    .src_zero  (req_src_zero),
    .eff_priv  (eff_priv),
    .virt_eff  (virt_eff),
    .priv_fail (priv_fail),
    .ro_fail   (ro_fail),
    .verdict   (verdict)
  );

  csrg_resp_reg #(.INSN_W(INSN_W), .CAUSE_W(CAUSE_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (req_valid),
    .in_verdict (verdict),
    .in_insn    (req_insn),
    .out_valid  (rsp_valid),
    .out_ok     (rsp_ok),
    .out_ill    (rsp_illegal),
    .out_virt   (rsp_virtual),
    .out_cause  (rsp_cause),
    .out_tval   (rsp_tval)
  );
endmodule

// File: rtl/csrg_checker.sv
module csrg_checker
  import csrg_pkg::*;
#(
  parameter int CAUSE_W = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic [CSR_ADDR_W-1:0] req_addr,
  input logic [1:0]            req_op,
  input logic                  req_src_zero,
  input logic [PRIV_W-1:0]     cur_priv,
  input logic                  virt_on,
  input logic                  priv_fail,
  input logic                  ro_fail,
  input logic                  rsp_valid,
  input logic                  rsp_ok,
  input logic                  rsp_illegal,
  input logic                  rsp_virtual,
  input logic [CAUSE_W-1:0]    rsp_cause
);
  AST_ONE_EXCEPTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_illegal && rsp_virtual)); // R9
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_ok, rsp_illegal, rsp_virtual}) == 1); // R9
  AST_PULSE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R7
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_ok && !rsp_illegal && !rsp_virtual); // R7
  AST_VIRT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_virtual |-> rsp_cause == CAUSE_W'(CODE_VIRTUAL)); // R2
  AST_ILL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> rsp_cause == CAUSE_W'(CODE_ILLEGAL)); // R3
  AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == OP_WRITE && req_addr[11:10] == 2'b11 |=> rsp_illegal); // R4
  AST_VU_SUPER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && virt_on && cur_priv == LVL_U && req_addr[9:8] == LVL_S
    && req_op == OP_READ |=> rsp_virtual); // R2
  AST_ZERO_RMW_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op[1] && req_src_zero && cur_priv == LVL_M |=> rsp_ok); // R5
  AST_MACHINE_FAIL_ILL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && priv_fail && req_addr[9:8] == LVL_M |=> rsp_illegal); // R3
  AST_CLEAN_OK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !priv_fail && !ro_fail |=> rsp_ok); // R6
endmodule

bind csr_priv_guard csrg_checker #(.CAUSE_W(CAUSE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_addr     (req_addr),
  .req_op       (req_op),
  .req_src_zero (req_src_zero),
  .cur_priv     (cur_priv),
  .virt_on      (virt_on),
  .priv_fail    (priv_fail),
  .ro_fail      (ro_fail),
  .rsp_valid    (rsp_valid),
  .rsp_ok       (rsp_ok),
  .rsp_illegal  (rsp_illegal),
  .rsp_virtual  (rsp_virtual),
  .rsp_cause    (rsp_cause)
);

// File: tb/tb_csr_priv_guard.sv
module tb_csr_priv_guard;
  localparam int INSN_W  = 32;
  localparam int CAUSE_W = 6;
  localparam int WATCHDOG = 100000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [11:0]       req_addr = '0;
  logic [1:0]        req_op = '0;
  logic              req_src_zero = 1'b0;
  logic [1:0]        cur_priv = '0;
  logic              virt_on = 1'b0;
  logic [INSN_W-1:0] req_insn = '0;
  logic              rsp_valid, rsp_ok, rsp_illegal, rsp_virtual;
  logic [CAUSE_W-1:0] rsp_cause;
  logic [INSN_W-1:0]  rsp_tval;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  csr_priv_guard #(.INSN_W(INSN_W), .CAUSE_W(CAUSE_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_op(req_op), .req_src_zero(req_src_zero), .cur_priv(cur_priv),
    .virt_on(virt_on), .req_insn(req_insn), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_illegal(rsp_illegal), .rsp_virtual(rsp_virtual),
    .rsp_cause(rsp_cause), .rsp_tval(rsp_tval)
  );

  // 0 allowed, 1 illegal, 2 virtual
  function automatic int model(input logic [11:0] a, input logic [1:0] op,
                               input logic sz, input logic [1:0] p, input logic v);
    int lvl, need;
    bit virt, wr, ro;
    virt = v && (p != 2'd3);
    lvl  = virt ? ((p == 2'd0) ? 0 : 1) : int'(p);
    need = int'(a[9:8]);
    wr   = (op == 2'd1) || (op >= 2'd2 && !sz);
    ro   = (a[11:10] == 2'b11) && wr;
    if (ro) return 1;
    if (lvl < need) return (virt && need <= 2) ? 2 : 1;
    return 0;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input string req, input logic [11:0] a, input logic [1:0] op,
                        input logic sz, input logic [1:0] p, input logic v);
    int e;
    logic [INSN_W-1:0] insn;
    insn = $urandom;
    e = model(a, op, sz, p, v);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_op = op; req_src_zero = sz;
    cur_priv = p; virt_on = v; req_insn = insn;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R7 valid"}, 64'(rsp_valid), 64'd1);
    check({req, " R9 verdict"}, {61'd0, rsp_virtual, rsp_illegal, rsp_ok},
          (e == 0) ? 64'd1 : (e == 1) ? 64'd2 : 64'd4);
    check({req, " cause R2 R3 R6"}, 64'(rsp_cause),
          (e == 0) ? 64'd0 : (e == 1) ? 64'd2 : 64'd22);
    check({req, " R8 tval"}, 64'(rsp_tval), (e == 0) ? 64'd0 : 64'(insn));
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R10 reset valid", 64'(rsp_valid), 64'd0);
    check("R10 reset flags", {61'd0, rsp_ok, rsp_illegal, rsp_virtual}, 64'd0);
    check("R10 reset cause/tval", 64'(rsp_cause) | 64'(rsp_tval), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", {60'd0, rsp_valid, rsp_ok, rsp_illegal, rsp_virtual}, 64'd0);

    access("R2 VU read sstatus",          12'h100, 2'd0, 1'b0, 2'd0, 1'b1);
    access("R3 U read S csr",             12'h100, 2'd0, 1'b0, 2'd0, 1'b0);
    access("R2 VS read hyp level",        12'h600, 2'd0, 1'b0, 2'd1, 1'b1);
    access("R3 VS read M csr",            12'h300, 2'd0, 1'b0, 2'd1, 1'b1);
    access("R6 S read S csr",             12'h100, 2'd0, 1'b0, 2'd1, 1'b0);
    access("R1 M ignores virt",           12'h300, 2'd1, 1'b0, 2'd3, 1'b1);
    access("R4 M write ro",               12'hF11, 2'd1, 1'b0, 2'd3, 1'b0);
    access("R4 U write ro U-level",       12'hC00, 2'd1, 1'b0, 2'd0, 1'b0);
    access("R4 VU write ro S-level",      12'hD00, 2'd1, 1'b0, 2'd0, 1'b1);
    access("R5 M set zero src ro",        12'hF11, 2'd2, 1'b1, 2'd3, 1'b0);
    access("R5 M clear nonzero ro",       12'hF11, 2'd3, 1'b0, 2'd3, 1'b0);
    access("R5 VU clear zero src S ro",   12'hD00, 2'd3, 1'b1, 2'd0, 1'b1);
    access("R1 U read U csr",             12'h001, 2'd0, 1'b0, 2'd0, 1'b0);

    @(negedge clk);
    check("R7 idle no pulse", {60'd0, rsp_valid, rsp_ok, rsp_illegal, rsp_virtual}, 64'd0);

    for (int i = 0; i < 2000; i++) begin
      logic [11:0] a;
      a = {2'($urandom_range(3)), 2'($urandom_range(3)), 8'($urandom)};
      access("R1 random", a, 2'($urandom_range(3)), 1'($urandom),
             2'($urandom_range(3)), 1'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule